// File: doc/BRIEF.md
# Faulting Instruction Capture Registers

This block works next to the exception logic of a coprocessor-0 control unit. When a synchronous exception is taken, it stores the 32-bit instruction word that caused the fault in a read-only register. If that instruction sits in a branch delay slot, it also stores the branch instruction in front of it in a second read-only register. Whether a capture happens depends on:

- the 5-bit cause code;
- whether a valid instruction word was available;
- the exception-level status bit;
- the delay-slot flag;
- the compressed-ISA mode flag;
- one enable bit for each register.

Software reads the two registers through a combinational register/select port at control register 8. Select 1 is the faulting word and select 2 is the prior branch word. Select 0 at register 8 holds the bad virtual address, which another unit owns. This block returns no hit for select 0.

The block has no streaming interface and no valid/ready handshake. The exception strobe is a single-cycle pulse that is always accepted, and the access port answers in the same cycle. Because nothing can stall, there is no back-pressure rule.

Top module: `fic_capture_top`

## Requirements
- R1: After reset both capture registers read as zero.
- R2: Cause codes 3, 5, 8, 9, 10, 11, 12, 13, 15 and 19 always qualify for capture. When the strobe is high, EXL is low, compressed mode is off and cfg_fault_en is 1, the faulting register takes word_at_pc at that clock edge. The new value can be read from the next cycle.
- R3: Cause codes 1, 2 and 4 qualify only when fetch_fault is 0. With fetch_fault set, for example on a misaligned fetch reported as cause 4, neither register changes.
- R4: Every other cause code (0, 6, 7, 14, 16, 17, 18, 20 to 31) leaves both registers unchanged.
- R5: A strobe taken while exl is 1 leaves both registers unchanged.
- R6: A strobe taken while compact_mode is 1 leaves both registers unchanged.
- R7: The branch register takes word_at_prev only on a qualifying strobe with in_delay_slot set and cfg_branch_en set. In every other case it keeps its value.
- R8: cfg_fault_en gates loading of the faulting register and cfg_branch_en gates loading of the branch register. Each bit acts independently of the other.
- R9: A read (acc_rd=1) at register 8 behaves as follows:
  - select 1 returns the faulting register with rd_hit=1 when cfg_fault_en is 1;
  - select 2 returns the branch register with rd_hit=1 when cfg_branch_en is 1;
  - if the matching enable is 0, acc_unimpl=1, rd_hit=0 and rd_data=0;
  - for any address that is not a hit, rd_data is 0.
- R10: A write (acc_wr=1) to register 8 at select 0, 1 or 2 has no effect on either register. Any access to register 8 with a select of 3 to 7 raises acc_illegal.
- R11: Without an exception strobe both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_take | input | 1 | Exception-taken strobe, one cycle |
| exc_cause | input | 5 | Cause code of the exception |
| fetch_fault | input | 1 | No valid instruction word exists (fault on fetch) |
| exl | input | 1 | Exception-level status bit |
| in_delay_slot | input | 1 | Faulting instruction is in a branch delay slot |
| compact_mode | input | 1 | Compressed-ISA mode active |
| word_at_pc | input | 32 | Instruction word at the exception PC |
| word_at_prev | input | 32 | Instruction word at exception PC minus 4 |
| cfg_fault_en | input | 1 | Enables the faulting-instruction register |
| cfg_branch_en | input | 1 | Enables the prior-branch register |
| acc_rd | input | 1 | Control-register read request |
| acc_wr | input | 1 | Control-register write request |
| acc_reg | input | 5 | Register number of the access |
| acc_sel | input | 3 | Select of the access |
| rd_data | output | 32 | Read data |
| rd_hit | output | 1 | This block answered the read |
| acc_unimpl | output | 1 | Read of a disabled capture register |
| acc_illegal | output | 1 | Access to register 8 with an undefined select |

## Verification
The bench sweeps all 32 cause codes against every combination of fetch_fault, exl and in_delay_slot. Each strobe carries fresh, distinct instruction words, so a stale register, a load from the wrong word, or a capture that should not have happened all show up as different read values. In this sweep, each qualifying cause is separated from each non-qualifying one, and the fetch-conditioned causes are split by fetch_fault. Separate patterns then clear each enable bit in turn, turn on compressed mode, write to the capture selects, and probe undefined selects. These patterns show that each gate works independently and that writes leave the registers untouched.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int CAUSE_W = 5;
  typedef logic [CAUSE_W-1:0] cause_t;

  typedef enum logic [1:0] {
    CAP_NEVER   = 2'd0,
    CAP_ALWAYS  = 2'd1,
    CAP_IF_WORD = 2'd2
  } cap_class_e;

  function automatic cap_class_e classify(input cause_t c);
    cap_class_e r;
    case (c)
      5'd3, 5'd5, 5'd8, 5'd9, 5'd10, 5'd11,
      5'd12, 5'd13, 5'd15, 5'd19: r = CAP_ALWAYS;
      5'd1, 5'd2, 5'd4:            r = CAP_IF_WORD;
      default:                     r = CAP_NEVER;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fic_cause_filter.sv
module fic_cause_filter
  import fic_pkg::*;
(
  input  logic   exc_take,
  input  cause_t exc_cause,
  input  logic   fetch_fault,
  input  logic   exl,
  input  logic   compact_mode,
  output logic   qualify
);
  cap_class_e cls;
  logic       cause_ok;

  always_comb begin
    cls = classify(exc_cause);
    case (cls)
      CAP_ALWAYS:  cause_ok = 1'b1;
      CAP_IF_WORD: cause_ok = !fetch_fault;
      default:     cause_ok = 1'b0;
    endcase
    qualify = exc_take && !exl && !compact_mode && cause_ok;
  end
endmodule

// File: rtl/fic_word_reg.sv
module fic_word_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/fic_read_mux.sv
module fic_read_mux #(
  parameter int DATA_W     = 32,
  parameter int REG_W      = 5,
  parameter int SEL_W      = 3,
  parameter int CAP_REG    = 8,
  parameter int FAULT_SEL  = 1,
  parameter int BRANCH_SEL = 2
) (
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic              fault_en,
  input  logic              branch_en,
  input  logic [DATA_W-1:0] fault_word,
  input  logic [DATA_W-1:0] branch_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit,
  output logic              acc_unimpl,
  output logic              acc_illegal
);
  localparam logic [REG_W-1:0] REG_ID  = REG_W'(CAP_REG);
  localparam logic [SEL_W-1:0] SEL_F   = SEL_W'(FAULT_SEL);
  localparam logic [SEL_W-1:0] SEL_B   = SEL_W'(BRANCH_SEL);
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(2);

  logic is_cap, at_f, at_b;

  always_comb begin
    is_cap      = (acc_reg == REG_ID);
    at_f        = is_cap && (acc_sel == SEL_F);
    at_b        = is_cap && (acc_sel == SEL_B);
    rd_hit      = acc_rd && ((at_f && fault_en) || (at_b && branch_en));
    acc_unimpl  = acc_rd && ((at_f && !fault_en) || (at_b && !branch_en));
    acc_illegal = (acc_rd || acc_wr) && is_cap && (acc_sel > SEL_MAX);
    rd_data     = '0;
    if (acc_rd && at_f && fault_en)  rd_data = fault_word;
    if (acc_rd && at_b && branch_en) rd_data = branch_word;
  end
endmodule

// File: rtl/fic_capture_top.sv
module fic_capture_top
  import fic_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int REG_W      = 5,
  parameter int SEL_W      = 3,
  parameter int CAP_REG    = 8,
  parameter int FAULT_SEL  = 1,
  parameter int BRANCH_SEL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_take,
  input  logic [4:0]        exc_cause,
  input  logic              fetch_fault,
  input  logic              exl,
  input  logic              in_delay_slot,
  input  logic              compact_mode,
  input  logic [DATA_W-1:0] word_at_pc,
  input  logic [DATA_W-1:0] word_at_prev,
  input  logic              cfg_fault_en,
  input  logic              cfg_branch_en,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic [SEL_W-1:0]  acc_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit,
  output logic              acc_unimpl,
  output logic              acc_illegal
);
  localparam int NSLOT = 2;

  logic              qualify;
  logic [NSLOT-1:0]  load;
  logic [DATA_W-1:0] din [NSLOT];
  logic [DATA_W-1:0] q   [NSLOT];
  logic [DATA_W-1:0] fault_word, branch_word;

  fic_cause_filter u_filter (
    .exc_take     (exc_take),
    .exc_cause    (cause_t'(exc_cause)),
    .fetch_fault  (fetch_fault),
    .exl          (exl),
    .compact_mode (compact_mode),
    .qualify      (qualify)
  );

  always_comb begin
    load[0] = qualify && cfg_fault_en;
    load[1] = qualify && cfg_branch_en && in_delay_slot;
    din[0]  = word_at_pc;
    din[1]  = word_at_prev;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    fic_word_reg #(.WIDTH(DATA_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load[i]),
      .din   (din[i]),
      .q     (q[i])
    );
  end

  assign fault_word  = q[0];
  assign branch_word = q[1];

  fic_read_mux #(
    .DATA_W(DATA_W), .REG_W(REG_W), .SEL_W(SEL_W), .CAP_REG(CAP_REG),
    .FAULT_SEL(FAULT_SEL), .BRANCH_SEL(BRANCH_SEL)
  ) u_mux (
    .acc_rd      (acc_rd),
    .acc_wr      (acc_wr),
    .acc_reg     (acc_reg),
    .acc_sel     (acc_sel),
    .fault_en    (cfg_fault_en),
    .branch_en   (cfg_branch_en),
    .fault_word  (fault_word),
    .branch_word (branch_word),
    .rd_data     (rd_data),
    .rd_hit      (rd_hit),
    .acc_unimpl  (acc_unimpl),
    .acc_illegal (acc_illegal)
  );
endmodule

// File: rtl/fic_checker.sv
module fic_checker #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_take,
  input logic [4:0]        exc_cause,
  input logic              exl,
  input logic              in_delay_slot,
  input logic              compact_mode,
  input logic [DATA_W-1:0] word_at_pc,
  input logic              cfg_fault_en,
  input logic              acc_rd,
  input logic [REG_W-1:0]  acc_reg,
  input logic [SEL_W-1:0]  acc_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_hit,
  input logic              acc_unimpl,
  input logic [DATA_W-1:0] fault_word,
  input logic [DATA_W-1:0] branch_word
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |=> ($stable(fault_word) && $stable(branch_word)));

  p_exl_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exl) |=> ($stable(fault_word) && $stable(branch_word)));

  p_compact_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && compact_mode) |=> ($stable(fault_word) && $stable(branch_word)));

  p_slot_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !in_delay_slot) |=> $stable(branch_word));

  p_syscall_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !exl && !compact_mode && cfg_fault_en && exc_cause == 5'd8)
      |=> (fault_word == $past(word_at_pc)));

  p_disabled_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_reg == REG_W'(8) && acc_sel == SEL_W'(1) && !cfg_fault_en)
      |-> (acc_unimpl && !rd_hit && rd_data == '0));
endmodule

bind fic_capture_top fic_checker #(.DATA_W(DATA_W), .REG_W(REG_W), .SEL_W(SEL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .exc_take      (exc_take),
  .exc_cause     (exc_cause),
  .exl           (exl),
  .in_delay_slot (in_delay_slot),
  .compact_mode  (compact_mode),
  .word_at_pc    (word_at_pc),
  .cfg_fault_en  (cfg_fault_en),
  .acc_rd        (acc_rd),
  .acc_reg       (acc_reg),
  .acc_sel       (acc_sel),
  .rd_data       (rd_data),
  .rd_hit        (rd_hit),
  .acc_unimpl    (acc_unimpl),
  .fault_word    (fault_word),
  .branch_word   (branch_word)
);

// File: tb/sim_fic_capture_top.sv
module sim_fic_capture_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_take = 1'b0;
  logic [4:0]  exc_cause = '0;
  logic        fetch_fault = 1'b0;
  logic        exl = 1'b0;
  logic        in_delay_slot = 1'b0;
  logic        compact_mode = 1'b0;
  logic [31:0] word_at_pc = '0;
  logic [31:0] word_at_prev = '0;
  logic        cfg_fault_en = 1'b1;
  logic        cfg_branch_en = 1'b1;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic [4:0]  acc_reg = '0;
  logic [2:0]  acc_sel = '0;
  logic [31:0] rd_data;
  logic        rd_hit, acc_unimpl, acc_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_f = '0;
  logic [31:0] exp_b = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fic_capture_top u0 (
    .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .exc_cause(exc_cause),
    .fetch_fault(fetch_fault), .exl(exl), .in_delay_slot(in_delay_slot),
    .compact_mode(compact_mode), .word_at_pc(word_at_pc), .word_at_prev(word_at_prev),
    .cfg_fault_en(cfg_fault_en), .cfg_branch_en(cfg_branch_en),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_reg(acc_reg), .acc_sel(acc_sel),
    .rd_data(rd_data), .rd_hit(rd_hit), .acc_unimpl(acc_unimpl), .acc_illegal(acc_illegal)
  );

  function automatic bit cause_qualifies(input int c, input bit ff);
    if (c == 3 || c == 5 || (c >= 8 && c <= 13) || c == 15 || c == 19) return 1'b1;
    if (c == 1 || c == 2 || c == 4) return !ff;
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_sel(input logic [2:0] s);
    acc_rd = 1'b1; acc_wr = 1'b0; acc_reg = 5'd8; acc_sel = s;
    #1;
  endtask

  task automatic check_both(input string req);
    read_sel(3'd1); check(req, rd_data, exp_f);
    read_sel(3'd2); check(req, rd_data, exp_b);
    acc_rd = 1'b0;
  endtask

  task automatic strobe(input int c, input bit ff, input bit x, input bit ds,
                        input bit cm, input logic [31:0] wp, input logic [31:0] wb);
    @(negedge clk);
    exc_take = 1'b1; exc_cause = 5'(c); fetch_fault = ff; exl = x;
    in_delay_slot = ds; compact_mode = cm; word_at_pc = wp; word_at_prev = wb;
    @(negedge clk);
    exc_take = 1'b0; exl = 1'b0; compact_mode = 1'b0; in_delay_slot = 1'b0;
    if (!x && !cm && cause_qualifies(c, ff)) begin
      if (cfg_fault_en) exp_f = wp;
      if (cfg_branch_en && ds) exp_b = wb;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_both("R1");

    // R2 R3 R4 R5 R7 R11: full sweep over cause, fetch_fault, exl, delay slot
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 8; k++) begin
        strobe(c, k[0], k[1], k[2], 1'b0,
               32'hA500_0000 | (c << 8) | k, 32'h5B00_0000 | (c << 8) | k);
        if (k[1])                         check_both("R5");
        else if (cause_qualifies(c, k[0])) check_both(k[2] ? "R7" : "R2");
        else if (c == 1 || c == 2 || c == 4) check_both("R3");
        else                               check_both("R4");
      end
    end

    // R11 idle hold across several cycles
    repeat (4) @(negedge clk);
    check_both("R11");

    // R6 compressed mode blocks capture
    strobe(8, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1111_1111, 32'h2222_2222);
    check_both("R6");

    // R8 fault enable off, branch still loads
    cfg_fault_en = 1'b0;
    strobe(10, 1'b0, 1'b0, 1'b1, 1'b0, 32'h3333_3333, 32'h4444_4444);
    read_sel(3'd1);
    check("R9", {31'd0, acc_unimpl}, 32'd1);
    check("R9", rd_data, 32'd0);
    check("R9", {31'd0, rd_hit}, 32'd0);
    cfg_fault_en = 1'b1;
    check_both("R8");

    // R8 branch enable off, fault still loads
    cfg_branch_en = 1'b0;
    strobe(13, 1'b0, 1'b0, 1'b1, 1'b0, 32'h5555_5555, 32'h6666_6666);
    read_sel(3'd2);
    check("R9", {31'd0, acc_unimpl}, 32'd1);
    check("R9", rd_data, 32'd0);
    cfg_branch_en = 1'b1;
    check_both("R8");

    // R9 hit flag and select 0 not answered
    read_sel(3'd1);
    check("R9", {31'd0, rd_hit}, 32'd1);
    read_sel(3'd0);
    check("R9", {30'd0, rd_hit, acc_unimpl}, 32'd0);
    check("R9", rd_data, 32'd0);
    acc_rd = 1'b0;

    // R10 writes ignored, undefined selects flagged
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      acc_rd = 1'b0; acc_wr = 1'b1; acc_reg = 5'd8; acc_sel = 3'(s);
      #1;
      check("R10", {31'd0, acc_illegal}, (s > 2) ? 32'd1 : 32'd0);
      @(negedge clk);
      acc_wr = 1'b0;
      check_both("R10");
    end
    read_sel(3'd5);
    check("R10", {31'd0, acc_illegal}, 32'd1);
    acc_reg = 5'd9; #1;
    check("R10", {31'd0, acc_illegal}, 32'd0);
    acc_rd = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule